// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single down-counting timer channel with a width of `W` bits (16 by default). It advances only on cycles where a one-cycle tick-enable input is high. This lets one fast system clock drive the channel at any slower counting rate. A load strobe writes a new terminal count and an operating mode together, and counting restarts from that cycle.

The 3-bit mode selects six output behaviours:

- a level that rises when the terminal count is reached;
- a one-shot level that falls there;
- a periodic one-tick strobe;
- a square wave;
- a single one-tick strobe, in a software-started and a gate-started form.

A rising gate edge restarts counting in the retriggerable modes. The channel also presents its readable count for a host interface to sample.

Both outputs are registered. They change on the same clock edge that applies a tick, a load or a gate restart.

Top module: `interval_chan`

## Requirements
- R1: During and after reset the channel is in mode 3 with a terminal count of 2^W. The wave output reads 1 and the count output reads 0 (2^W truncated to W bits).
- R2: A load strobe captures `load_val_i` as the terminal count C, with a value of 0 meaning 2^W. It captures `load_mode_i` on the same edge and sets the elapsed tick count d to 0. A load takes priority over a tick in the same cycle.
- R3: In a cycle with no tick, no load and no gate rising edge, neither output changes.
- R4: Mode 0: wave is 1 when d >= C and 0 otherwise. It stays 1 until the next load.
- R5: Mode 1: wave is 1 while d < C and 0 from then on.
- R6: Mode 2: wave is 1 only when d is a nonzero multiple of C. The count output reads C - (d mod C), taken mod 2^W.
- R7: Mode 3: wave is 1 when (d mod C) < (C+1)/2 (integer division) and 0 otherwise. The count output reads C - ((2d) mod C), taken mod 2^W.
- R8: Modes 4 and 5: wave is 1 only when d == C.
- R9: In modes 1, 2, 3 and 5, a gate rising edge (gate 1 now, 0 in the previous cycle) sets d to 0, and a tick in that cycle is dropped. In modes 0 and 4 a gate edge has no effect and ticks still count.
- R10: In modes 0, 1, 4 and 5 the count output reads (C - d) mod 2^W, so it wraps past zero.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: Both outputs show the new state on the same edge that applies the tick, load or restart; there is no further cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| gate_i | input | 1 | Gate level; a rising edge restarts counting in modes 1, 2, 3, 5 |
| load_i | input | 1 | Load strobe for the count value and mode |
| load_val_i | input | W | Terminal count; 0 stands for 2^W |
| load_mode_i | input | 3 | Operating mode code captured on load |
| wave_o | output | 1 | Registered output waveform |
| count_o | output | W | Registered readable count |

## Verification
Every result is due one edge after its cause: the edge that applies a tick, load or gate restart also updates `wave_o` and `count_o`.

The bench therefore drives inputs on a falling edge and compares both outputs on the next falling edge. In between, exactly one rising edge has acted on them, and the bench's elapsed-tick model has been advanced once to match.

Idle steps with no tick are interleaved in every sweep. The outputs after such a step must equal the outputs before it. Gate-edge steps carry a tick, so that a dropped tick and a counted tick predict different values.

// File: rtl/chan_pkg.sv
package chan_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto rate and square (R11)
  function automatic mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return mode_e'(raw);
    endcase
  endfunction

  function automatic logic retrig_mode(input mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTROBE);
  endfunction

endpackage

// File: rtl/chan_phase.sv
module chan_phase #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W:0]   cnt_i,
  output logic [W-1:0] ela_n,
  output logic [W-1:0] ph_n,
  output logic [W-1:0] ph2_n,
  output logic [W:0]   dsat_n
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W-1:0] ela_q, ph_q, ph2_q;
  logic [W:0]   dsat_q;
  logic [W:0]   ph_inc, ph2_sum;

  always_comb begin
    ph_inc  = {1'b0, ph_q} + ONE;
    ph2_sum = {1'b0, ph2_q} + {{(W-1){1'b0}}, 2'b10};
    ela_n   = ela_q;
    ph_n    = ph_q;
    ph2_n   = ph2_q;
    dsat_n  = dsat_q;
    if (clr_i) begin
      ela_n  = '0;
      ph_n   = '0;
      ph2_n  = '0;
      dsat_n = '0;
    end else if (adv_i) begin
      ela_n = ela_q + 1'b1;
      ph_n  = (ph_inc == cnt_i) ? '0 : ph_inc[W-1:0];
      if (cnt_i == ONE)
        ph2_n = '0;
      else if (ph2_sum >= cnt_i)
        ph2_n = W'(ph2_sum - cnt_i);
      else
        ph2_n = ph2_sum[W-1:0];
      if (dsat_q <= cnt_i)
        dsat_n = dsat_q + ONE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ela_q  <= '0;
      ph_q   <= '0;
      ph2_q  <= '0;
      dsat_q <= '0;
    end else begin
      ela_q  <= ela_n;
      ph_q   <= ph_n;
      ph2_q  <= ph2_n;
      dsat_q <= dsat_n;
    end
  end

  // phase stays inside the period (R6)
  assert_phase_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ({1'b0, ph_q} < cnt_i));
  // restart clears elapsed ticks (R9)
  assert_restart_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (dsat_q == '0 && ela_q == '0));

endmodule

// File: rtl/chan_wave.sv
module chan_wave #(
  parameter int W = 16
) (
  input  chan_pkg::mode_e mode_i,
  input  logic [W:0]      cnt_i,
  input  logic [W:0]      dsat_i,
  input  logic [W-1:0]    ela_i,
  input  logic [W-1:0]    ph_i,
  input  logic [W-1:0]    ph2_i,
  output logic            wave_o,
  output logic [W-1:0]    count_o
);
  import chan_pkg::*;

  logic [W:0] half, lin_diff, rate_diff, sq_diff;
  logic       reached, at_term, nonzero;

  always_comb begin
    half      = (cnt_i + {{W{1'b0}}, 1'b1}) >> 1;
    lin_diff  = cnt_i - {1'b0, ela_i};
    rate_diff = cnt_i - {1'b0, ph_i};
    sq_diff   = cnt_i - {1'b0, ph2_i};
    reached   = dsat_i >= cnt_i;
    at_term   = dsat_i == cnt_i;
    nonzero   = dsat_i != '0;
    case (mode_i)
      MD_TERM: begin
        wave_o  = reached;
        count_o = lin_diff[W-1:0];
      end
      MD_ONESHOT: begin
        wave_o  = !reached;
        count_o = lin_diff[W-1:0];
      end
      MD_RATE: begin
        wave_o  = (ph_i == '0) && nonzero;
        count_o = rate_diff[W-1:0];
      end
      MD_SQUARE: begin
        wave_o  = {1'b0, ph_i} < half;
        count_o = sq_diff[W-1:0];
      end
      default: begin
        wave_o  = at_term;
        count_o = lin_diff[W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/interval_chan.sv
module interval_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [2:0]   load_mode_i,
  output logic         wave_o,
  output logic [W-1:0] count_o
);
  import chan_pkg::*;

  localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

  mode_e        mode_q, mode_n;
  logic [W:0]   cnt_q, cnt_n;
  logic         gate_q, rise, clr;
  logic [W-1:0] ela_n, ph_n, ph2_n;
  logic [W:0]   dsat_n;
  logic         wave_n;
  logic [W-1:0] count_n;

  always_comb begin
    rise   = gate_i && !gate_q;
    clr    = load_i || (rise && retrig_mode(mode_q));
    mode_n = mode_q;
    cnt_n  = cnt_q;
    if (load_i) begin
      mode_n = norm_mode(load_mode_i);
      cnt_n  = (load_val_i == '0) ? FULL : {1'b0, load_val_i};
    end
  end

  chan_phase #(.W(W)) u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (clr),
    .adv_i  (tick_i),
    .cnt_i  (cnt_q),
    .ela_n  (ela_n),
    .ph_n   (ph_n),
    .ph2_n  (ph2_n),
    .dsat_n (dsat_n)
  );

  chan_wave #(.W(W)) u_wave (
    .mode_i  (mode_n),
    .cnt_i   (cnt_n),
    .dsat_i  (dsat_n),
    .ela_i   (ela_n),
    .ph_i    (ph_n),
    .ph2_i   (ph2_n),
    .wave_o  (wave_n),
    .count_o (count_n)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= MD_SQUARE;
      cnt_q   <= FULL;
      gate_q  <= 1'b0;
      wave_o  <= 1'b1;
      count_o <= '0;
    end else begin
      mode_q  <= mode_n;
      cnt_q   <= cnt_n;
      gate_q  <= gate_i;
      wave_o  <= wave_n;
      count_o <= count_n;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    rst_i |=> (mode_q == MD_SQUARE && cnt_q == FULL && wave_o && count_o == '0));

  assert_zero_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && load_val_i == '0) |=> (cnt_q == FULL));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !tick_i && !rise) |=> ($stable(wave_o) && $stable(count_o)));

  assert_sticky_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q == MD_TERM && wave_o && !load_i) |=> wave_o);

  assert_gate_ignored_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    ((mode_q == MD_TERM || mode_q == MD_SWSTROBE) && rise && tick_i && !load_i)
      |=> (count_o == $past(count_o) - {{(W-1){1'b0}}, 1'b1}));

  assert_down_by_one_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    ((mode_q == MD_TERM || mode_q == MD_ONESHOT || mode_q == MD_SWSTROBE ||
      mode_q == MD_HWSTROBE) && tick_i && !load_i && !rise)
      |=> (count_o == $past(count_o) - {{(W-1){1'b0}}, 1'b1}));

  assert_alias_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && load_mode_i[2:1] == 2'b11) |=> (mode_q == MD_RATE || mode_q == MD_SQUARE));

endmodule

// File: tb/test_interval_chan.sv
module test_interval_chan;
  localparam int W    = 6;
  localparam int FULL = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         tick, gate, load;
  logic [W-1:0] load_val;
  logic [2:0]   load_mode;
  logic         wave;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  int m_mode, m_raw, m_c, m_d;
  bit m_gate;

  always #2 clk = ~clk;

  interval_chan #(.W(W)) i_interval_chan (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .gate_i(gate), .load_i(load),
    .load_val_i(load_val), .load_mode_i(load_mode), .wave_o(wave), .count_o(count)
  );

  function automatic int fold(input int raw);
    if (raw == 6) return 2;
    if (raw == 7) return 3;
    return raw;
  endfunction

  function automatic bit exp_wave(input int m, input int c, input int d);
    case (m)
      0: return d >= c;
      1: return d < c;
      2: return (d % c == 0) && (d != 0);
      3: return (d % c) < ((c + 1) / 2);
      default: return d == c;
    endcase
  endfunction

  function automatic int exp_count(input int m, input int c, input int d);
    int v;
    case (m)
      2: v = c - (d % c);
      3: v = c - ((2 * d) % c);
      default: v = c - d;
    endcase
    return ((v % FULL) + FULL) % FULL;
  endfunction

  function automatic string wave_tag(input int raw);
    case (raw)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic string count_tag(input int raw);
    case (raw)
      2: return "R6";
      3: return "R7";
      6, 7: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (mode %0d C %0d d %0d)",
               tag, got, exp, m_raw, m_c, m_d);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input bit t, input bit l, input int val, input int md, input bit g,
                      input string wtag, input string ctag);
    tick = t; load = l; load_val = W'(val); load_mode = 3'(md); gate = g;
    if (l) begin
      m_c = (val == 0) ? FULL : val;
      m_raw = md;
      m_mode = fold(md);
      m_d = 0;
    end else if (g && !m_gate && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
      m_d = 0;
    end else if (t) begin
      m_d++;
    end
    m_gate = g;
    @(negedge clk);
    chk(wtag, int'(wave), int'(exp_wave(m_mode, m_c, m_d)));
    chk(ctag, int'(count), exp_count(m_mode, m_c, m_d));
    tick = 1'b0; load = 1'b0;
  endtask

  initial begin
    int vals[9] = '{1, 2, 3, 4, 5, 7, 10, 63, 0};
    rst = 1'b1; tick = 0; gate = 0; load = 0; load_val = '0; load_mode = '0;
    m_gate = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(wave), 1);
    chk("R1", int'(count), 0);
    rst = 1'b0;
    m_raw = 3; m_mode = 3; m_c = FULL; m_d = 0;
    @(negedge clk);
    chk("R1", int'(wave), 1);
    chk("R1", int'(count), 0);
    for (int k = 0; k < 40; k++) step(1, 0, 0, 0, 0, "R1", "R7");

    for (int md = 0; md < 8; md++) begin
      foreach (vals[i]) begin
        int c;
        c = (vals[i] == 0) ? FULL : vals[i];
        step(0, 1, vals[i], md, 0, "R2", (vals[i] == 0) ? "R2" : count_tag(md));
        step(1, 0, 0, 0, 0, "R12", "R12");
        for (int k = 1; k < 2 * c + 3; k++) begin
          if (k % 5 == 0) step(0, 0, 0, 0, 0, "R3", "R3");
          step(1, 0, 0, 0, 0, wave_tag(md), (vals[i] == 0) ? "R2" : count_tag(md));
        end
      end
      // gate edge behaviour
      step(0, 1, 5, md, 0, "R9", "R9");
      for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, wave_tag(md), count_tag(md));
      step(1, 0, 0, 0, 1, "R9", "R9");
      for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 1, "R9", "R9");
      step(1, 0, 0, 0, 0, "R9", "R9");
      step(1, 0, 0, 0, 1, "R9", "R9");
      step(0, 0, 0, 0, 1, "R3", "R3");
      // load wins over a tick in the same cycle
      step(1, 1, 3, md, 0, "R2", "R2");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule